// File: doc/BRIEF.md
# Lockable Identification Page Controller

This block owns a 256-byte identification page that sits beside, and apart from, the main memory array of a serial memory device. A serial front end decodes each frame and hands this block a stream of strobes: the opcode at the start of the frame, the address once it is complete, each received data byte, a request to advance to the next output byte, and an end-of-frame strobe when chip select returns high. The block answers with the byte to shift out and a one-cycle request to start a self-timed write cycle.

Four opcodes are handled: reading the page, writing the page, reading the lock state and locking the page. Bytes received in a page-write frame are gathered in a staging buffer and copied into the page only when the frame closes with the write-enable latch set and at least one data byte received. A single sticky lock bit, set by a qualified lock frame, makes the page read-only from then on. The lock state is read back through the same read path by setting a selector bit in the address. The byte index inside the page is taken from the low address bits and wraps inside the page both when reading and when writing.

Top module: `idp_ctrl`

## Requirements
- R1: After reset the lock bit is 0, every page byte reads as 8'hFF, and `wr_start` is 0.
- R2: Opcode code 1 (page read): from the cycle after the address strobe, `rd_data` shows the page byte at index `addr[7:0]`; each `rd_next` strobe moves to the following index, and index 255 is followed by index 0.
- R3: Opcode code 2 (page write): each data byte received after the address is staged at the current index, which then advances with wrap from 255 to 0; at end of frame, with `wel` high and the page unlocked, every staged byte replaces its page byte and `wr_start` is high for exactly the one cycle after the end-of-frame strobe.
- R4: A page-write frame that ends with `wel` low, or with no data byte after the address, leaves every page byte unchanged and raises no `wr_start`.
- R5: Opcode code 3 (lock read) with address bit 10 set: `rd_data` equals 8'h01 when locked and 8'h00 when unlocked; all other address bits have no effect.
- R6: Opcode code 4 (lock) with address bit 10 set, at least one data byte after the address, and `wel` high at end of frame, sets the lock bit in the cycle after the end-of-frame strobe and raises `wr_start` for that one cycle.
- R7: A lock frame with address bit 10 clear, with `wel` low at end of frame, or with no data byte, leaves the lock bit at 0 and raises no `wr_start`.
- R8: Once set, the lock bit stays set until reset; while it is set, page-write and lock frames change no page byte and raise no `wr_start`.
- R9: Opcode codes 0, 5, 6 and 7 select no operation: their address, data, advance and end-of-frame strobes change no state, `rd_data` is 8'h00, and no `wr_start` is raised.
- R10: Opcode code 3 with address bit 10 clear reads the page exactly as opcode code 1 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Opcode strobe at the start of a frame |
| cmd_op | input | 3 | Decoded opcode code (1 page read, 2 page write, 3 lock read, 4 lock) |
| addr_valid | input | 1 | Address-complete strobe |
| addr | input | 24 | Frame address |
| data_valid | input | 1 | Received data byte strobe |
| data_in | input | 8 | Received data byte |
| rd_next | input | 1 | Advance to the next output byte |
| frame_end | input | 1 | Chip select returned high at a byte boundary |
| wel | input | 1 | Write-enable latch from the status block |
| rd_data | output | 8 | Byte to shift out |
| wr_start | output | 1 | One-cycle request to start a self-timed write cycle |
| id_locked | output | 1 | Current lock bit |

## Verification
The assertions watch, on every cycle, that the lock bit never falls once set, that it only rises right after an end-of-frame strobe with the write-enable latch high, that `wr_start` is a single-cycle pulse qualified by end of frame, write enable and an unlocked page, that a locked page never starts a write cycle, and that a lock-status read returns the lock bit. Which bytes land where, index wrap on read and write, and the dropping of frames that lack a data byte, carry the wrong selector bit or an unknown opcode, can only be shown by the bench's scenarios against its reference model of the page.

// File: rtl/idp_pkg.sv
package idp_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_RD_PAGE = 3'd1,
    OP_WR_PAGE = 3'd2,
    OP_RD_LOCK = 3'd3,
    OP_LOCK    = 3'd4
  } idp_op_e;

  // Map a raw opcode code onto the handled set; anything else is no-op.
  function automatic idp_op_e decode_op(logic [2:0] code);
    case (code)
      3'd1:    return OP_RD_PAGE;
      3'd2:    return OP_WR_PAGE;
      3'd3:    return OP_RD_LOCK;
      3'd4:    return OP_LOCK;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic logic op_takes_data(idp_op_e op);
    return (op == OP_WR_PAGE) || (op == OP_LOCK);
  endfunction

  function automatic logic op_sends_data(idp_op_e op);
    return (op == OP_RD_PAGE) || (op == OP_RD_LOCK);
  endfunction

  // Index step inside a page of 'depth' bytes, wrapping to zero.
  function automatic int unsigned wrap_next(int unsigned idx, int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/idp_frame_track.sv
module idp_frame_track #(
  parameter int ADDR_W = 24,
  parameter int PAGE_BYTES = 256,
  localparam int IDX_W = $clog2(PAGE_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic                 addr_valid,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 data_valid,
  input  logic                 rd_next,
  input  logic                 frame_end,
  output idp_pkg::idp_op_e     cur_op,
  output logic [ADDR_W-1:0]    cur_addr,
  output logic                 addr_seen,
  output logic                 got_data,
  output logic [IDX_W-1:0]     ptr,
  output logic                 byte_take
);
  import idp_pkg::*;

  logic read_step;
  logic [IDX_W-1:0] ptr_inc;

  assign ptr_inc   = IDX_W'(wrap_next(int'(ptr), PAGE_BYTES));
  assign byte_take = data_valid && addr_seen && op_takes_data(cur_op)
                     && !frame_end && !cmd_valid;
  assign read_step = rd_next && addr_seen && op_sends_data(cur_op)
                     && !frame_end && !cmd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_op    <= OP_NONE;
      cur_addr  <= '0;
      addr_seen <= 1'b0;
      got_data  <= 1'b0;
      ptr       <= '0;
    end else if (frame_end) begin
      cur_op    <= OP_NONE;
      addr_seen <= 1'b0;
      got_data  <= 1'b0;
    end else if (cmd_valid) begin
      cur_op    <= decode_op(cmd_op);
      addr_seen <= 1'b0;
      got_data  <= 1'b0;
    end else begin
      if (addr_valid && (cur_op != OP_NONE) && !addr_seen) begin
        cur_addr  <= addr;
        ptr       <= addr[IDX_W-1:0];
        addr_seen <= 1'b1;
      end
      if (byte_take) begin
        ptr      <= ptr_inc;
        got_data <= 1'b1;
      end
      if (read_step) begin
        ptr <= ptr_inc;
      end
    end
  end

endmodule

// File: rtl/idp_page_store.sv
module idp_page_store #(
  parameter int PAGE_BYTES = 256,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_take,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              commit,
  input  logic              clear,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_byte
);

  logic [DATA_W-1:0] page_q [PAGE_BYTES];
  logic [DATA_W-1:0] stage_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  // Staging buffer: one slot per page byte, with a valid mask.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) stage_q[i] <= '0;
    end else begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (byte_take && (wr_idx == IDX_W'(i))) begin
          stage_q[i] <= wr_byte;
          mask_q[i]  <= 1'b1;
        end else if (clear) begin
          mask_q[i]  <= 1'b0;
        end
      end
    end
  end

  // Page contents: staged bytes land only on a qualified commit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) page_q[i] <= '1;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (mask_q[i]) page_q[i] <= stage_q[i];
      end
    end
  end

  assign rd_byte = page_q[rd_idx];

endmodule

// File: rtl/idp_commit_ctl.sv
module idp_commit_ctl #(
  parameter int ADDR_W = 24,
  parameter int LOCK_SEL_BIT = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_end,
  input  logic                wel,
  input  idp_pkg::idp_op_e    cur_op,
  input  logic [ADDR_W-1:0]   cur_addr,
  input  logic                addr_seen,
  input  logic                got_data,
  output logic                page_commit,
  output logic                lock_commit,
  output logic                wr_start,
  output logic                locked
);
  import idp_pkg::*;

  logic frame_ok;

  assign frame_ok    = frame_end && addr_seen && got_data && wel && !locked;
  assign page_commit = frame_ok && (cur_op == OP_WR_PAGE);
  assign lock_commit = frame_ok && (cur_op == OP_LOCK) && cur_addr[LOCK_SEL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_start <= 1'b0;
      locked   <= 1'b0;
    end else begin
      wr_start <= page_commit || lock_commit;
      if (lock_commit) locked <= 1'b1;
    end
  end

endmodule

// File: rtl/idp_ctrl.sv
module idp_ctrl #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int PAGE_BYTES = 256,
  parameter int LOCK_SEL_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] data_in,
  input  logic              rd_next,
  input  logic              frame_end,
  input  logic              wel,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_start,
  output logic              id_locked
);
  import idp_pkg::*;

  localparam int IDX_W = $clog2(PAGE_BYTES);

  idp_op_e           cur_op;
  logic [ADDR_W-1:0] cur_addr;
  logic              addr_seen;
  logic              got_data;
  logic [IDX_W-1:0]  ptr;
  logic              byte_take;
  logic              page_commit;
  logic              lock_commit;
  logic [DATA_W-1:0] page_byte;
  logic              rd_lock_sel;
  logic              rd_page_sel;

  idp_frame_track #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_track (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .addr_valid(addr_valid), .addr(addr), .data_valid(data_valid),
    .rd_next(rd_next), .frame_end(frame_end), .cur_op(cur_op),
    .cur_addr(cur_addr), .addr_seen(addr_seen), .got_data(got_data),
    .ptr(ptr), .byte_take(byte_take)
  );

  idp_page_store #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .byte_take(byte_take), .wr_idx(ptr),
    .wr_byte(data_in), .commit(page_commit),
    .clear(frame_end || cmd_valid), .rd_idx(ptr), .rd_byte(page_byte)
  );

  idp_commit_ctl #(.ADDR_W(ADDR_W), .LOCK_SEL_BIT(LOCK_SEL_BIT)) u_commit (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .wel(wel),
    .cur_op(cur_op), .cur_addr(cur_addr), .addr_seen(addr_seen),
    .got_data(got_data), .page_commit(page_commit),
    .lock_commit(lock_commit), .wr_start(wr_start), .locked(id_locked)
  );

  // Output byte select: lock status, page byte, or idle zero.
  assign rd_lock_sel = addr_seen && (cur_op == OP_RD_LOCK) && cur_addr[LOCK_SEL_BIT];
  assign rd_page_sel = addr_seen && ((cur_op == OP_RD_PAGE) ||
                       ((cur_op == OP_RD_LOCK) && !cur_addr[LOCK_SEL_BIT]));

  always_comb begin
    if (rd_lock_sel)      rd_data = {{(DATA_W-1){1'b0}}, id_locked};
    else if (rd_page_sel) rd_data = page_byte;
    else                  rd_data = '0;
  end

endmodule

// File: rtl/idp_ctrl_chk.sv
module idp_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_end,
  input logic              wel,
  input logic              wr_start,
  input logic              id_locked,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_lock_sel,
  input logic              page_commit,
  input logic              lock_commit
);

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    id_locked |=> id_locked);

  p_lock_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_locked) |-> ($past(frame_end) && $past(wel)));

  p_start_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> ($past(frame_end) && $past(wel) && !$past(id_locked)));

  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);

  p_locked_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_locked && frame_end) |=> !wr_start);

  p_lock_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lock_sel |-> (rd_data == {{(DATA_W-1){1'b0}}, id_locked}));

  p_commit_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(page_commit && lock_commit));

endmodule

bind idp_ctrl idp_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .wel(wel),
  .wr_start(wr_start), .id_locked(id_locked), .rd_data(rd_data),
  .rd_lock_sel(rd_lock_sel), .page_commit(page_commit),
  .lock_commit(lock_commit)
);

// File: tb/idp_ctrl_bench.sv
module idp_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic        addr_valid = 1'b0;
  logic [23:0] addr = '0;
  logic        data_valid = 1'b0;
  logic [7:0]  data_in = '0;
  logic        rd_next = 1'b0;
  logic        frame_end = 1'b0;
  logic        wel = 1'b0;
  logic [7:0]  rd_data;
  logic        wr_start;
  logic        id_locked;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  idp_ctrl u_idp_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .addr_valid(addr_valid), .addr(addr), .data_valid(data_valid),
    .data_in(data_in), .rd_next(rd_next), .frame_end(frame_end), .wel(wel),
    .rd_data(rd_data), .wr_start(wr_start), .id_locked(id_locked)
  );

  // ---------------- behavioural reference model ----------------
  int  m_page [256];
  int  m_pend [int];
  int  m_op, m_addr, m_ptr;
  bit  m_has_addr, m_got, m_locked, m_start;

  function automatic int model_rd();
    if (!m_has_addr) return 0;
    if (m_op == 3 && m_addr[10]) return m_locked ? 1 : 0;
    if (m_op == 1 || m_op == 3) return m_page[m_ptr];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_page[i]) m_page[i] = 8'hFF;
      m_pend.delete();
      m_op = 0; m_addr = 0; m_ptr = 0;
      m_has_addr = 0; m_got = 0; m_locked = 0; m_start = 0;
    end else begin
      m_start = 0;
      if (frame_end) begin
        if (m_has_addr && m_got && wel && !m_locked) begin
          if (m_op == 2) begin
            foreach (m_pend[k]) m_page[k] = m_pend[k];
            m_start = 1;
          end else if (m_op == 4 && m_addr[10]) begin
            m_locked = 1;
            m_start = 1;
          end
        end
        m_pend.delete();
        m_op = 0; m_has_addr = 0; m_got = 0;
      end else if (cmd_valid) begin
        m_op = (cmd_op >= 1 && cmd_op <= 4) ? int'(cmd_op) : 0;
        m_pend.delete();
        m_has_addr = 0; m_got = 0;
      end else begin
        if (addr_valid && m_op != 0 && !m_has_addr) begin
          m_addr = int'(addr); m_ptr = int'(addr[7:0]); m_has_addr = 1;
        end else if (data_valid && m_has_addr && (m_op == 2 || m_op == 4)) begin
          m_pend[m_ptr] = int'(data_in);
          m_ptr = (m_ptr + 1) % 256; m_got = 1;
        end else if (rd_next && m_has_addr && (m_op == 1 || m_op == 3)) begin
          m_ptr = (m_ptr + 1) % 256;
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the clock edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(rd_data) == model_rd(), "R2 per-cycle rd_data", int'(rd_data), model_rd());
      chk(wr_start == m_start, "R3 per-cycle wr_start", int'(wr_start), int'(m_start));
      chk(id_locked == m_locked, "R8 per-cycle lock", int'(id_locked), int'(m_locked));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
    cmd_valid = 0; addr_valid = 0; data_valid = 0; rd_next = 0; frame_end = 0;
  endtask

  task automatic open_frame(int op, int a);
    cmd_valid = 1; cmd_op = 3'(op); tick();
    addr_valid = 1; addr = 24'(a); tick();
  endtask

  task automatic put_byte(int d);
    data_valid = 1; data_in = 8'(d); tick();
  endtask

  task automatic close_frame(int exp_start, string tag);
    frame_end = 1; tick();
    chk(int'(wr_start) == exp_start, tag, int'(wr_start), exp_start);
    tick();
  endtask

  task automatic read_step(int exp, string tag);
    chk(int'(rd_data) == exp, tag, int'(rd_data), exp);
    rd_next = 1; tick();
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1 reset state
    chk(id_locked == 0, "R1 lock after reset", int'(id_locked), 0);
    chk(wr_start == 0, "R1 wr_start after reset", int'(wr_start), 0);
    open_frame(1, 24'h000000);
    read_step(8'hFF, "R1 page byte 0 after reset");
    read_step(8'hFF, "R1 page byte 1 after reset");
    close_frame(0, "R2 read frame starts no write");

    // R4 write with wel low
    wel = 0;
    open_frame(2, 24'h000005); put_byte(8'h10);
    close_frame(0, "R4 write without wel");
    // R4 write with no data byte
    wel = 1;
    open_frame(2, 24'h000005);
    close_frame(0, "R4 write without data byte");
    open_frame(1, 24'h000005);
    read_step(8'hFF, "R4 page byte 5 unchanged");
    close_frame(0, "R2 read frame");

    // R3 write with wrap inside the page
    open_frame(2, 24'h0300FE);
    put_byte(8'hA1); put_byte(8'hB2); put_byte(8'hC3);
    close_frame(1, "R3 write starts cycle");
    // R2 read across the wrap
    open_frame(1, 24'h0000FD);
    read_step(8'hFF, "R2 byte FD");
    read_step(8'hA1, "R2 byte FE");
    read_step(8'hB2, "R2 byte FF");
    read_step(8'hC3, "R3 wrapped byte 00");
    read_step(8'hFF, "R2 byte 01");
    close_frame(0, "R2 read frame");

    // R5 lock status, R10 selector clear reads page
    open_frame(3, 24'h000400);
    chk(int'(rd_data) == 0, "R5 lock status unlocked", int'(rd_data), 0);
    tick();
    close_frame(0, "R5 lock read frame");
    open_frame(3, 24'h0000FE);
    read_step(8'hA1, "R10 selector clear reads page");
    close_frame(0, "R10 frame");

    // R9 unknown opcode
    open_frame(6, 24'h000010); put_byte(8'h55); rd_next = 1; tick();
    chk(int'(rd_data) == 0, "R9 unknown op rd_data", int'(rd_data), 0);
    close_frame(0, "R9 unknown op no write");
    open_frame(0, 24'h000410); put_byte(8'h55);
    close_frame(0, "R9 opcode 0 no write");

    // R7 lock attempts that must be dropped
    open_frame(4, 24'h000000); put_byte(8'h00);
    close_frame(0, "R7 lock with selector clear");
    wel = 0;
    open_frame(4, 24'h000400); put_byte(8'h00);
    close_frame(0, "R7 lock without wel");
    wel = 1;
    open_frame(4, 24'h000400);
    close_frame(0, "R7 lock without data byte");
    chk(id_locked == 0, "R7 still unlocked", int'(id_locked), 0);

    // R6 proper lock
    open_frame(4, 24'hFF0400); put_byte(8'h00);
    close_frame(1, "R6 lock starts cycle");
    chk(id_locked == 1, "R6 locked", int'(id_locked), 1);
    open_frame(3, 24'h000400);
    chk(int'(rd_data) == 1, "R5 lock status locked", int'(rd_data), 1);
    tick();
    close_frame(0, "R5 lock read frame");

    // R8 locked page refuses writes and relocks
    open_frame(2, 24'h0000FE); put_byte(8'h77);
    close_frame(0, "R8 write refused when locked");
    open_frame(4, 24'h000400); put_byte(8'h00);
    close_frame(0, "R8 lock refused when locked");
    open_frame(1, 24'h0000FE);
    read_step(8'hA1, "R8 page byte unchanged");
    close_frame(0, "R8 read frame");
    repeat (5) tick();
    chk(id_locked == 1, "R8 lock sticky", int'(id_locked), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule